// File: doc/BRIEF.md
# Shared RAM Bank Arbiter

This block sits in front of one synchronous single-port RAM bank and picks one of three requesters on every clock: a processor port, a general DMA port and a crypto-engine DMA port. A chip with several banks instantiates one arbiter per bank, so masters that address different banks proceed in the same cycle. The processor normally owns the bank. The two DMA ports take the cycles the processor leaves empty, and they share those cycles fairly by alternating.

A wait counter on each DMA port stops the processor from starving it. When a waiting DMA port has lost `starve_limit` consecutive cycles, it takes the next cycle ahead of the processor. All ports use byte addresses on a RAM that is two byte lanes wide. The processor and general DMA ports ignore address bit 0 and use the byte strobes. The crypto port always moves 16 bits. At an odd byte address it spans two RAM words, and the arbiter splits that access into two byte-lane accesses on consecutive grants of its own.

Top module: `bank_arbiter`

## Requirements
- R1: At most one of `cpu_gnt`, `dma_gnt`, `cry_gnt` is high in any cycle, and a grant is given only to a port whose request is high.
- R2: When neither DMA port has reached its wait limit, a processor request wins over both DMA requests.
- R3: A DMA request is granted in any cycle in which the processor does not request and the other DMA port does not compete.
- R4: When both DMA ports compete in consecutive cycles and the processor is idle, the grants alternate between them.
- R5: With the processor requesting every cycle, a waiting DMA port loses exactly `starve_limit` cycles and is granted in the next one.
- R6: The `*_rvalid` of the granted port rises exactly one cycle after its grant, with that port's read data, and no other port's `*_rvalid` rises in that cycle.
- R7: A write changes only the byte lanes whose strobe bit is 1 (bit 0 selects data bits 7:0, bit 1 selects bits 15:8), and it takes effect in the grant cycle.
- R8: A crypto access at an even byte address completes with one grant and moves the full 16-bit word at word address `addr>>1`.
- R9: A crypto access at an odd byte address A needs two grants, and `cry_gnt` rises only on the second. Data bits 7:0 go to bits 15:8 of word A>>1, and data bits 15:8 go to bits 7:0 of word (A>>1)+1. A read assembles the same two bytes in the same order.
- R10: A DMA port's wait count clears when the port is granted, so a port that keeps requesting under a busy processor is granted once every `starve_limit`+1 cycles.
- R11: After reset, no grant and no `*_rvalid` is high while no request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| starve_limit | input | CNT_W | Number of lost cycles before a DMA port overrides the processor |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_be | input | 2 | Processor byte strobes |
| cpu_gnt | output | 1 | Processor access accepted this cycle |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 16 | Processor read data |
| dma_req | input | 1 | General DMA request |
| dma_we | input | 1 | General DMA write enable |
| dma_addr | input | ADDR_W | General DMA byte address |
| dma_wdata | input | 16 | General DMA write data |
| dma_be | input | 2 | General DMA byte strobes |
| dma_gnt | output | 1 | General DMA access accepted |
| dma_rvalid | output | 1 | General DMA read data valid |
| dma_rdata | output | 16 | General DMA read data |
| cry_req | input | 1 | Crypto DMA request |
| cry_we | input | 1 | Crypto DMA write enable |
| cry_addr | input | ADDR_W | Crypto DMA byte address |
| cry_wdata | input | 16 | Crypto DMA write data |
| cry_be | input | 2 | Crypto DMA byte strobes |
| cry_gnt | output | 1 | Crypto access completed (final part granted) |
| cry_rvalid | output | 1 | Crypto read data valid |
| cry_rdata | output | 16 | Crypto read data, reassembled for odd addresses |

## Verification
The bench holds the processor busy and counts exactly how many cycles a DMA port loses before it is granted. A guard that is off by one, or that never clears its count, moves the grant pattern away from cycles 3 and 7 of a nine-cycle window. It runs both DMA ports against each other to catch a round-robin pointer that never advances, which would give every cycle to one of them. It also writes and reads back a crypto word at an odd address around pre-filled neighbours. A wrong lane swap, a missing second grant or a wrong word increment corrupts one of the two bytes, clobbers the neighbouring byte, or returns the halves reversed.

// File: rtl/bank_arb_pkg.sv
`timescale 1ns/1ps
package bank_arb_pkg;
   localparam int NUM_PORTS = 3;
   localparam int NUM_SEC   = 2;
   typedef enum logic [1:0] {
      PORT_CPU = 2'd0,
      PORT_DMA = 2'd1,
      PORT_CRY = 2'd2
   } port_e;
   typedef logic [NUM_PORTS-1:0] slot_t;
endpackage

// File: rtl/bank_arb_starve.sv
`timescale 1ns/1ps
module bank_arb_starve #(
   parameter int CNT_W = 4,
   parameter int NSEC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] limit,
   input  logic [NSEC-1:0]  req,
   input  logic [NSEC-1:0]  won,
   output logic [NSEC-1:0]  urgent
);
   for (genvar i = 0; i < NSEC; i++) begin : g_wait
      logic [CNT_W-1:0] wait_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  wait_cnt <= '0;
         else if (won[i] || !req[i])  wait_cnt <= '0;
         else if (wait_cnt < limit)   wait_cnt <= wait_cnt + 1'b1;
      end
      assign urgent[i] = req[i] && (wait_cnt >= limit);
   end
endmodule

// File: rtl/bank_arb_pick.sv
`timescale 1ns/1ps
module bank_arb_pick
   import bank_arb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_cpu,
   input  logic [NUM_SEC-1:0]  req_sec,
   input  logic [NUM_SEC-1:0]  urgent,
   output slot_t               slot
);
   // last_cry = 1: crypto port was the most recent secondary winner
   logic last_cry;

   function automatic logic [NUM_SEC-1:0] rr_pick(input logic [NUM_SEC-1:0] m,
                                                  input logic lc);
      if (m == 2'b11) return lc ? 2'b01 : 2'b10;
      return m;
   endfunction

   always_comb begin
      slot = '0;
      if (|urgent)          slot = {rr_pick(urgent, last_cry), 1'b0};
      else if (req_cpu)     slot = 3'b001;
      else if (|req_sec)    slot = {rr_pick(req_sec, last_cry), 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   last_cry <= 1'b1;
      else if (slot[PORT_DMA])      last_cry <= 1'b0;
      else if (slot[PORT_CRY])      last_cry <= 1'b1;
   end
endmodule

// File: rtl/bank_arb_split.sv
`timescale 1ns/1ps
module bank_arb_split #(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 8,
   localparam int DW    = 2 * LANE_W,
   localparam int WA    = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic [1:0]        be,
   input  logic              won,
   input  logic [DW-1:0]     q,
   output logic [WA-1:0]     m_addr,
   output logic [DW-1:0]     m_wdata,
   output logic [1:0]        m_be,
   output logic              last_part,
   output logic [DW-1:0]     rdata
);
   logic          odd, phase, cap_q, fin_odd_q;
   logic [LANE_W-1:0] hold;
   logic [WA-1:0] base;

   assign odd       = addr[0];
   assign base      = addr[ADDR_W-1:1];
   assign last_part = !odd || phase;

   always_comb begin
      if (!odd) begin
         m_addr  = base;
         m_wdata = wdata;
         m_be    = be;
      end else if (!phase) begin
         m_addr  = base;
         m_wdata = {wdata[LANE_W-1:0], {LANE_W{1'b0}}};
         m_be    = {be[0], 1'b0};
      end else begin
         m_addr  = base + 1'b1;
         m_wdata = {{LANE_W{1'b0}}, wdata[DW-1:LANE_W]};
         m_be    = {1'b0, be[1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= 1'b0;
         cap_q     <= 1'b0;
         fin_odd_q <= 1'b0;
         hold      <= '0;
      end else begin
         if (won) phase <= odd && !phase;
         cap_q     <= won && odd && !phase;
         fin_odd_q <= won && odd && phase;
         if (cap_q) hold <= q[DW-1:LANE_W];
      end
   end

   assign rdata = fin_odd_q ? {q[LANE_W-1:0], hold} : q;
endmodule

// File: rtl/bank_arb_ram.sv
`timescale 1ns/1ps
module bank_arb_ram #(
   parameter int WA     = 8,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int DW    = LANE_W * LANES,
   localparam int DEPTH = 1 << WA
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [WA-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic [LANES-1:0] be,
   output logic [DW-1:0]    q
);
   logic [DW-1:0] mem [DEPTH];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (en && we && be[l])
            mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (en) q <= mem[addr];
   end
endmodule

// File: rtl/bank_arbiter.sv
`timescale 1ns/1ps
module bank_arbiter
   import bank_arb_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter int CNT_W  = 4,
   localparam int DW    = LANE_W * LANES,
   localparam int WA    = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  starve_limit,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [LANES-1:0]  cpu_be,
   output logic              cpu_gnt,
   output logic              cpu_rvalid,
   output logic [DW-1:0]     cpu_rdata,
   input  logic              dma_req,
   input  logic              dma_we,
   input  logic [ADDR_W-1:0] dma_addr,
   input  logic [DW-1:0]     dma_wdata,
   input  logic [LANES-1:0]  dma_be,
   output logic              dma_gnt,
   output logic              dma_rvalid,
   output logic [DW-1:0]     dma_rdata,
   input  logic              cry_req,
   input  logic              cry_we,
   input  logic [ADDR_W-1:0] cry_addr,
   input  logic [DW-1:0]     cry_wdata,
   input  logic [LANES-1:0]  cry_be,
   output logic              cry_gnt,
   output logic              cry_rvalid,
   output logic [DW-1:0]     cry_rdata
);
   if (LANES != 2) begin : g_bad_lanes
      $error("bank_arbiter: crypto lane split needs LANES == 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("bank_arbiter: ADDR_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("bank_arbiter: CNT_W must be at least 1");
   end

   slot_t              slot;
   logic [NUM_SEC-1:0] urgent;
   logic               cry_last;
   logic [WA-1:0]      cry_maddr, m_addr;
   logic [DW-1:0]      cry_mwdata, m_wdata, q, cry_rd;
   logic [1:0]         cry_mbe;
   logic [LANES-1:0]   m_be;
   logic               m_we, m_en;
   logic [2:0]         rv_q;

   bank_arb_starve #(.CNT_W(CNT_W), .NSEC(NUM_SEC)) u_starve (
      .clk    (clk),
      .rst_n  (rst_n),
      .limit  (starve_limit),
      .req    ({cry_req, dma_req}),
      .won    (slot[PORT_CRY:PORT_DMA]),
      .urgent (urgent)
   );

   bank_arb_pick u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_cpu (cpu_req),
      .req_sec ({cry_req, dma_req}),
      .urgent  (urgent),
      .slot    (slot)
   );

   bank_arb_split #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (cry_addr),
      .wdata     (cry_wdata),
      .be        (cry_be),
      .won       (slot[PORT_CRY]),
      .q         (q),
      .m_addr    (cry_maddr),
      .m_wdata   (cry_mwdata),
      .m_be      (cry_mbe),
      .last_part (cry_last),
      .rdata     (cry_rd)
   );

   always_comb begin
      m_en    = |slot;
      m_we    = 1'b0;
      m_addr  = '0;
      m_wdata = '0;
      m_be    = '0;
      unique case (1'b1)
         slot[PORT_CPU]: begin
            m_we = cpu_we; m_addr = cpu_addr[ADDR_W-1:1];
            m_wdata = cpu_wdata; m_be = cpu_be;
         end
         slot[PORT_DMA]: begin
            m_we = dma_we; m_addr = dma_addr[ADDR_W-1:1];
            m_wdata = dma_wdata; m_be = dma_be;
         end
         slot[PORT_CRY]: begin
            m_we = cry_we; m_addr = cry_maddr;
            m_wdata = cry_mwdata; m_be = cry_mbe;
         end
         default: ;
      endcase
   end

   bank_arb_ram #(.WA(WA), .LANE_W(LANE_W), .LANES(LANES)) u_ram (
      .clk   (clk),
      .en    (m_en),
      .we    (m_we),
      .addr  (m_addr),
      .wdata (m_wdata),
      .be    (m_be),
      .q     (q)
   );

   assign cpu_gnt = slot[PORT_CPU];
   assign dma_gnt = slot[PORT_DMA];
   assign cry_gnt = slot[PORT_CRY] && cry_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rv_q <= '0;
      else        rv_q <= {cry_gnt, dma_gnt, cpu_gnt};
   end

   assign cpu_rvalid = rv_q[PORT_CPU];
   assign dma_rvalid = rv_q[PORT_DMA];
   assign cry_rvalid = rv_q[PORT_CRY];
   assign cpu_rdata  = q;
   assign dma_rdata  = q;
   assign cry_rdata  = cry_rd;
endmodule

// File: rtl/bank_arbiter_chk.sv
`timescale 1ns/1ps
module bank_arbiter_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] starve_limit,
   input logic             cpu_req,
   input logic             cpu_gnt,
   input logic             cpu_rvalid,
   input logic             dma_req,
   input logic             dma_gnt,
   input logic             dma_rvalid,
   input logic             cry_req,
   input logic             cry_gnt,
   input logic             cry_rvalid
);
   logic [CNT_W+1:0] dma_lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       dma_lost <= '0;
      else if (!dma_req || dma_gnt)     dma_lost <= '0;
      else if (dma_lost != '1)          dma_lost <= dma_lost + 1'b1;
   end

   p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_gnt, dma_gnt, cry_gnt}));

   p_grant_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt |-> cpu_req) and (dma_gnt |-> dma_req) and (cry_gnt |-> cry_req));

   p_cpu_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !dma_req && !cry_req) |-> cpu_gnt);

   p_idle_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && dma_req && !cry_req) |-> dma_gnt);

   p_bounded_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_lost <= ({2'b00, starve_limit} + 1'b1));

   p_cpu_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |=> (cpu_rvalid && !dma_rvalid && !cry_rvalid));

   p_dma_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt |=> (dma_rvalid && !cpu_rvalid && !cry_rvalid));

   p_cry_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cry_rvalid |-> $past(cry_gnt));
endmodule

bind bank_arbiter bank_arbiter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/bank_arbiter_bench.sv
`timescale 1ns/1ps
module bank_arbiter_bench;
   localparam int PERIOD = 10;
   localparam int AW = 9;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] lim = 4'd15;
   logic [2:0]    req = '0, we = '0;
   logic [AW-1:0] addr [3];
   logic [15:0]   wd [3];
   logic [1:0]    be [3];
   logic [2:0]    gnt, rvalid;
   logic [15:0]   rdata [3];
   int n_chk = 0, n_fail = 0;

   always #(PERIOD/2) clk = ~clk;

   bank_arbiter u_bank_arbiter (
      .clk(clk), .rst_n(rst_n), .starve_limit(lim),
      .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]), .cpu_wdata(wd[0]), .cpu_be(be[0]),
      .cpu_gnt(gnt[0]), .cpu_rvalid(rvalid[0]), .cpu_rdata(rdata[0]),
      .dma_req(req[1]), .dma_we(we[1]), .dma_addr(addr[1]), .dma_wdata(wd[1]), .dma_be(be[1]),
      .dma_gnt(gnt[1]), .dma_rvalid(rvalid[1]), .dma_rdata(rdata[1]),
      .cry_req(req[2]), .cry_we(we[2]), .cry_addr(addr[2]), .cry_wdata(wd[2]), .cry_be(be[2]),
      .cry_gnt(gnt[2]), .cry_rvalid(rvalid[2]), .cry_rdata(rdata[2])
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input int p, input logic w, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] b,
                         output logic [15:0] rd, output int waits, output logic rv);
      waits = 0;
      @(negedge clk);
      req[p] = 1'b1; we[p] = w; addr[p] = a; wd[p] = d; be[p] = b;
      #1;
      while (!gnt[p]) begin
         waits++;
         @(negedge clk); #1;
      end
      @(negedge clk);
      req[p] = 1'b0; we[p] = 1'b0;
      rv = rvalid[p];
      rd = rdata[p];
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk("R11 no grant after reset", {29'd0, gnt}, 32'd0);
      chk("R11 no rvalid after reset", {29'd0, rvalid}, 32'd0);
   endtask

   task automatic t_cpu_lanes;
      logic [15:0] rd; int w; logic rv;
      access(0, 1'b1, 9'h020, 16'hA5C3, 2'b11, rd, w, rv);
      access(0, 1'b1, 9'h021, 16'h00FF, 2'b01, rd, w, rv);
      access(0, 1'b0, 9'h020, 16'h0000, 2'b11, rd, w, rv);
      chk("R6 cpu rvalid one cycle after grant", {31'd0, rv}, 32'd1);
      chk("R7 strobe writes only lane 0", {16'd0, rd}, 32'h0000A5FF);
      access(0, 1'b1, 9'h020, 16'h7700, 2'b10, rd, w, rv);
      access(0, 1'b0, 9'h020, 16'h0000, 2'b11, rd, w, rv);
      chk("R7 strobe writes only lane 1", {16'd0, rd}, 32'h000077FF);
   endtask

   task automatic t_idle_slot;
      logic [15:0] rd; int w; logic rv;
      access(1, 1'b1, 9'h040, 16'h3C3C, 2'b11, rd, w, rv);
      chk("R3 dma granted at once when cpu idle", w, 0);
      access(1, 1'b0, 9'h040, 16'h0000, 2'b11, rd, w, rv);
      chk("R6 dma read data", {16'd0, rd}, 32'h00003C3C);
   endtask

   task automatic t_cpu_priority;
      logic [5:0] seen_dma, seen_cpu;
      lim = 4'd15;
      @(negedge clk);
      req[0] = 1'b1; addr[0] = '0; req[1] = 1'b1; addr[1] = 9'h040;
      seen_dma = '0; seen_cpu = '0;
      for (int i = 0; i < 6; i++) begin
         #1; seen_dma[i] = gnt[1]; seen_cpu[i] = gnt[0];
         @(negedge clk);
      end
      req[0] = 1'b0; req[1] = 1'b0;
      chk("R2 dma never wins below limit", {26'd0, seen_dma}, 32'd0);
      chk("R2 cpu wins every cycle", {26'd0, seen_cpu}, 32'h3F);
   endtask

   task automatic t_starve;
      logic [8:0] pat;
      @(negedge clk); lim = 4'd3;
      @(negedge clk);
      req[0] = 1'b1; addr[0] = '0; req[1] = 1'b1; we[1] = 1'b0; addr[1] = 9'h040;
      pat = '0;
      for (int i = 0; i < 9; i++) begin
         #1; pat[i] = gnt[1];
         @(negedge clk);
      end
      req[0] = 1'b0; req[1] = 1'b0;
      chk("R5 first forced grant after 3 losses", {31'd0, pat[3]}, 32'd1);
      chk("R10 count cleared, grants at 3 and 7 only", {23'd0, pat}, 32'h088);
      lim = 4'd15;
   endtask

   task automatic t_round_robin;
      logic [1:0] prev; int bad;
      @(negedge clk);
      req[1] = 1'b1; we[1] = 1'b0; addr[1] = 9'h040;
      req[2] = 1'b1; we[2] = 1'b0; addr[2] = 9'h040; be[2] = 2'b11;
      prev = 2'b00; bad = 0;
      for (int i = 0; i < 6; i++) begin
         #1;
         if (!$onehot(gnt[2:1]) || gnt[2:1] == prev) bad++;
         prev = gnt[2:1];
         @(negedge clk);
      end
      req[1] = 1'b0; req[2] = 1'b0;
      chk("R4 dma and crypto alternate", bad, 0);
   endtask

   task automatic t_cry_even;
      logic [15:0] rd; int w; logic rv;
      access(2, 1'b1, 9'h060, 16'h1234, 2'b11, rd, w, rv);
      chk("R8 even crypto write takes one grant", w, 0);
      access(0, 1'b0, 9'h060, 16'h0000, 2'b11, rd, w, rv);
      chk("R8 even crypto word stored", {16'd0, rd}, 32'h00001234);
      access(2, 1'b0, 9'h060, 16'h0000, 2'b11, rd, w, rv);
      chk("R8 even crypto read", {16'd0, rd}, 32'h00001234);
   endtask

   task automatic t_cry_odd;
      logic [15:0] rd; int w; logic rv;
      access(0, 1'b1, 9'h030, 16'h1111, 2'b11, rd, w, rv);
      access(0, 1'b1, 9'h032, 16'h2222, 2'b11, rd, w, rv);
      access(2, 1'b1, 9'h031, 16'hBEEF, 2'b11, rd, w, rv);
      chk("R9 odd crypto write needs two grants", w, 1);
      access(0, 1'b0, 9'h030, 16'h0000, 2'b11, rd, w, rv);
      chk("R9 low byte into high lane of first word", {16'd0, rd}, 32'h0000EF11);
      access(0, 1'b0, 9'h032, 16'h0000, 2'b11, rd, w, rv);
      chk("R9 high byte into low lane of next word", {16'd0, rd}, 32'h000022BE);
      access(2, 1'b0, 9'h031, 16'h0000, 2'b11, rd, w, rv);
      chk("R6 crypto rvalid after final grant", {31'd0, rv}, 32'd1);
      chk("R9 odd crypto read reassembled", {16'd0, rd}, 32'h0000BEEF);
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      for (int p = 0; p < 3; p++) begin
         addr[p] = '0; wd[p] = '0; be[p] = 2'b11;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cpu_lanes();
      t_idle_slot();
      t_cpu_priority();
      t_starve();
      t_round_robin();
      t_cry_even();
      t_cry_odd();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
   end
endmodule